// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Match

This block is an 8-bit up-counter whose count enable comes from one of several sources. The source can be the system clock, one of four taps on a free-running prescaler, or one of the two edge kinds on an external input pin, sampled into the clock domain. The counter either runs freely through the full 8-bit range, or clears after it reaches a programmable compare value. On every count step it checks whether it has reached the all-ones value (overflow) and whether it equals the compare register (match). Each event gives a one-cycle pulse and sets a sticky status bit.

Software uses a small register port. There are four write addresses and a combinational read port. Through it software loads or reads the counter, sets the compare value, picks the mode and the source, and clears the sticky bits. Loading the counter suppresses the match on the next count step, so a value written equal to the compare register does not fire at once.

Top module: `tmr8_top`

## Requirements
- R1: After reset the counter, compare register, control and both sticky flags read 0, and both pulse outputs are low.
- R2: Register addresses: 0 control (bit 3 mode, bits 2:0 source select), 1 counter, 2 compare, 3 status (bit 0 match flag, bit 1 overflow flag). A write becomes visible on the next clock. `rd_data` shows the addressed register combinationally. A compare write is used by the very next comparison.
- R3: Source select 000 holds the counter. Source select 001 steps it on every clock.
- R4: The prescaler is a 10-bit counter, cleared by reset, that increments every clock. Selects 010, 011, 100 and 101 step the counter in cycles where the prescaler's low 3, 6, 8 or 10 bits are all ones (divide by 8, 64, 256, 1024).
- R5: The pin passes through two synchronizing flops and an edge register. Select 110 steps on falling edges and 111 on rising edges, one step per edge, taken on the third clock edge after the pin changes.
- R6: With mode 0, a step at 0xFF wraps the counter to 0. Any other step adds one.
- R7: With mode 1, a step taken while the counter equals the compare value clears it to 0. A step at 0xFF also wraps to 0.
- R8: A step taken at 0xFF pulses `ovf_pulse` for one cycle on the next clock, in both modes.
- R9: A step taken while the counter equals the compare value pulses `cmp_pulse` for one cycle on the next clock.
- R10: A counter write overrides any step in the same cycle. The first step after it produces no match pulse but still counts.
- R11: Each sticky flag is set by its pulse and cleared by writing 1 to its status bit. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Addressed register contents |
| ext_pin | input | 1 | External count input |
| count_o | output | 8 | Current counter value |
| cmp_pulse | output | 1 | One-cycle compare match pulse |
| ovf_pulse | output | 1 | One-cycle overflow pulse |
| cmp_flag | output | 1 | Sticky compare match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default values: an 8-bit counter and a 10-bit prescaler with taps at 3, 6, 8 and 10 bits. With an 8-bit range, a full wrap takes 256 steps at one per clock. The divide-by-1024 tap fires every 1024 cycles. So overflow, clear-on-compare and every prescaler tap can each be reached many times within a few tens of thousands of cycles. Random source switching lands on all eight selects, including both pin edge kinds, and directed runs hit compare values of 0xFF, counter writes equal to the compare value, and a clear in the same cycle as a set.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    typedef enum logic [2:0] {
        SRC_OFF  = 3'd0,
        SRC_CLK  = 3'd1,
        SRC_P8   = 3'd2,
        SRC_P64  = 3'd3,
        SRC_P256 = 3'd4,
        SRC_P1K  = 3'd5,
        SRC_FALL = 3'd6,
        SRC_RISE = 3'd7
    } src_sel_e;

    localparam int MODE_BIT = 3;
    localparam int NUM_TAPS = 4;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
    parameter int PRE_W = 10,
    parameter int TAP_SH [tmr8_pkg::NUM_TAPS] = '{3, 6, 8, 10}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [tmr8_pkg::NUM_TAPS-1:0] tap_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < tmr8_pkg::NUM_TAPS; i++) begin : g_tap
        assign tap_o[i] = &st_q.pre[TAP_SH[i]-1:0];
    end
endmodule

// File: rtl/tmr8_edge.sv
module tmr8_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.s3;
    assign fall_o = ~st_q.s2 & st_q.s3;
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic [2:0]       src_o,
    output logic [CNT_W-1:0] count_o,
    output logic             cmp_pulse,
    output logic             ovf_pulse,
    output logic             cmp_flag,
    output logic             ovf_flag
);
    import tmr8_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic             mode;
        logic [2:0]       src;
        logic             blk;
        logic             cmp_p;
        logic             ovf_p;
        logic             cmp_s;
        logic             ovf_s;
    } core_state_t;

    core_state_t st_d, st_q;

    logic wr_cnt, at_max, at_cmp;

    assign wr_cnt = wr_en && (wr_addr == ADDR_CNT);
    assign at_max = (st_q.cnt == CNT_MAX);
    assign at_cmp = (st_q.cnt == st_q.cmp);

    always_comb begin
        st_d       = st_q;
        st_d.cmp_p = 1'b0;
        st_d.ovf_p = 1'b0;

        if (wr_cnt) begin
            st_d.cnt = wr_data;
            st_d.blk = 1'b1;
        end else if (tick_i) begin
            st_d.ovf_p = at_max;
            st_d.cmp_p = at_cmp && !st_q.blk;
            st_d.blk   = 1'b0;
            if (at_max || (st_q.mode && at_cmp)) st_d.cnt = '0;
            else                                 st_d.cnt = st_q.cnt + 1'b1;
        end

        if (wr_en && (wr_addr == ADDR_CTRL)) begin
            st_d.mode = wr_data[MODE_BIT];
            st_d.src  = wr_data[2:0];
        end
        if (wr_en && (wr_addr == ADDR_CMP)) st_d.cmp = wr_data;
        if (wr_en && (wr_addr == ADDR_STAT)) begin
            st_d.cmp_s = st_q.cmp_s & ~wr_data[0];
            st_d.ovf_s = st_q.ovf_s & ~wr_data[1];
        end
        st_d.cmp_s = st_d.cmp_s | st_d.cmp_p;
        st_d.ovf_s = st_d.ovf_s | st_d.ovf_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[MODE_BIT] = st_q.mode;
                rd_data[2:0]      = st_q.src;
            end
            ADDR_CNT:  rd_data = st_q.cnt;
            ADDR_CMP:  rd_data = st_q.cmp;
            default: begin
                rd_data[0] = st_q.cmp_s;
                rd_data[1] = st_q.ovf_s;
            end
        endcase
    end

    assign src_o     = st_q.src;
    assign count_o   = st_q.cnt;
    assign cmp_pulse = st_q.cmp_p;
    assign ovf_pulse = st_q.ovf_p;
    assign cmp_flag  = st_q.cmp_s;
    assign ovf_flag  = st_q.ovf_s;
endmodule

// File: rtl/tmr8_top.sv
module tmr8_top #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_pin,
    output logic [CNT_W-1:0] count_o,
    output logic             cmp_pulse,
    output logic             ovf_pulse,
    output logic             cmp_flag,
    output logic             ovf_flag
);
    import tmr8_pkg::*;

    logic [NUM_TAPS-1:0] tap;
    logic                pin_rise, pin_fall, tick;
    logic [2:0]          src;

    tmr8_prescale #(.PRE_W(PRE_W)) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tap_o (tap)
    );

    tmr8_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    always_comb begin
        case (src_sel_e'(src))
            SRC_OFF:  tick = 1'b0;
            SRC_CLK:  tick = 1'b1;
            SRC_P8:   tick = tap[0];
            SRC_P64:  tick = tap[1];
            SRC_P256: tick = tap[2];
            SRC_P1K:  tick = tap[3];
            SRC_FALL: tick = pin_fall;
            default:  tick = pin_rise;
        endcase
    end

    tmr8_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .src_o     (src),
        .count_o   (count_o),
        .cmp_pulse (cmp_pulse),
        .ovf_pulse (ovf_pulse),
        .cmp_flag  (cmp_flag),
        .ovf_flag  (ovf_flag)
    );
endmodule

// File: rtl/tmr8_checks.sv
module tmr8_checks #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [2:0]       src,
    input logic [CNT_W-1:0] count_o,
    input logic             cmp_pulse,
    input logic             ovf_pulse,
    input logic             cmp_flag,
    input logic             ovf_flag
);
    logic wr_cnt;
    assign wr_cnt = wr_en && (wr_addr == 2'd1);

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 3'd0 && !wr_cnt) |=> $stable(count_o)); // R3
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count_o == $past(wr_data))); // R10
    AST_WRITE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> !cmp_pulse); // R10
    AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_pulse) |-> ($past(count_o) == '1)); // R8
    AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count_o == '0)); // R6
    AST_CMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |-> cmp_flag); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_flag); // R11
endmodule

bind tmr8_top tmr8_checks #(.CNT_W(CNT_W)) i_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .src       (src),
    .count_o   (count_o),
    .cmp_pulse (cmp_pulse),
    .ovf_pulse (ovf_pulse),
    .cmp_flag  (cmp_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_tmr8_top.sv
`timescale 1ns/1ps
module test_tmr8_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic       ext_pin = 1'b0;
    logic [7:0] rd_data, count_o;
    logic       cmp_pulse, ovf_pulse, cmp_flag, ovf_flag;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    tmr8_top i_tmr8_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_pin(ext_pin), .count_o(count_o), .cmp_pulse(cmp_pulse),
        .ovf_pulse(ovf_pulse), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
    );

    // Reference model built from the requirements
    logic [9:0] m_pre;
    logic       m_p1, m_p2, m_p3;
    logic [7:0] m_cnt, m_cmp;
    logic       m_mode, m_blk, m_cp, m_op, m_cs, m_os;
    logic [2:0] m_src;

    function automatic logic m_tick();
        case (m_src)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2: return m_pre[2:0] == 3'h7;
            3'd3: return m_pre[5:0] == 6'h3f;
            3'd4: return m_pre[7:0] == 8'hff;
            3'd5: return m_pre == 10'h3ff;
            3'd6: return !m_p2 && m_p3;
            default: return m_p2 && !m_p3;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_mode, m_src};
            2'd1: return m_cnt;
            2'd2: return m_cmp;
            default: return {6'b0, m_os, m_cs};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = '0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
            m_cnt = '0; m_cmp = '0; m_mode = 0; m_src = '0;
            m_blk = 0; m_cp = 0; m_op = 0; m_cs = 0; m_os = 0;
        end else begin
            logic tk;
            tk = m_tick();
            m_cp = 0; m_op = 0;
            if (wr_en && wr_addr == 2'd1) begin
                m_cnt = wr_data; m_blk = 1;
            end else if (tk) begin
                m_op = (m_cnt == 8'hff);
                m_cp = (m_cnt == m_cmp) && !m_blk;
                m_blk = 0;
                if (m_cnt == 8'hff || (m_mode && m_cnt == m_cmp)) m_cnt = 0;
                else m_cnt = m_cnt + 1;
            end
            if (wr_en && wr_addr == 2'd0) begin
                m_mode = wr_data[3]; m_src = wr_data[2:0];
            end
            if (wr_en && wr_addr == 2'd2) m_cmp = wr_data;
            if (wr_en && wr_addr == 2'd3) begin
                m_cs = m_cs & ~wr_data[0];
                m_os = m_os & ~wr_data[1];
            end
            m_cs = m_cs | m_cp;
            m_os = m_os | m_op;
            m_pre = m_pre + 1;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_pin;
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("count", count_o, m_cnt);
        chk("cmp_pulse R9", {7'b0, cmp_pulse}, {7'b0, m_cp});
        chk("ovf_pulse R8", {7'b0, ovf_pulse}, {7'b0, m_op});
        chk("cmp_flag R11", {7'b0, cmp_flag}, {7'b0, m_cs});
        chk("ovf_flag R11", {7'b0, ovf_flag}, {7'b0, m_os});
        chk("rd_data R2", rd_data, m_read(rd_addr));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
        wr_en = 1'b0;
        rd_addr = 2'($urandom_range(0, 3));
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #12 rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #0.1 chk("reset read", rd_data, 8'h00);
        end
        compare();

        cur_req = "R3";                 // stopped, then every clock
        run(5);
        wr(0, 8'h01);
        run(10);

        cur_req = "R6";                 // normal-mode wrap with overflow R8
        wr(1, 8'hFC);
        run(8);

        cur_req = "R7";                 // clear on compare R9
        wr(2, 8'h05);
        wr(0, 8'h09);
        wr(1, 8'h00);
        run(20);
        cur_req = "R8";                 // compare at 0xFF in CTC still overflows
        wr(2, 8'hFF);
        wr(1, 8'hFD);
        run(6);

        cur_req = "R10";                // write equal to compare is blocked once
        wr(2, 8'h10);
        wr(1, 8'h10);
        run(3);
        wr(1, 8'h0E);
        run(6);

        cur_req = "R11";                // W1C and set-wins
        wr(3, 8'h03);
        wr(2, 8'h02);
        wr(1, 8'h02);
        run(3);
        wr(3, 8'h01);
        run(2);
        wr(0, 8'h09);
        wr(1, 8'h01);
        step();
        wr(3, 8'h03);                   // coincides with a match step
        run(3);

        cur_req = "R5";                 // external pin edges
        wr(0, 8'h07);
        for (int i = 0; i < 12; i++) begin ext_pin = ~ext_pin; run(3); end
        wr(0, 8'h06);
        for (int i = 0; i < 12; i++) begin ext_pin = ~ext_pin; run(2); end
        ext_pin = 1'b1; step(); ext_pin = 1'b0; run(5);

        cur_req = "R4";                 // prescaler taps
        for (int s = 2; s <= 5; s++) begin
            wr(0, 8'(s));
            run(2100);
        end

        cur_req = "R2";                 // random mix
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(0, 99) < 30) ext_pin = ~ext_pin;
            if ($urandom_range(0, 99) < 4) begin
                wr_en = 1'b1;
                wr_addr = 2'($urandom_range(0, 3));
                wr_data = 8'($urandom);
            end
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule